// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation A/D converter inside a microcontroller. Software configures it through a small byte-wide register bus: a configuration register holds a power-down bit and a 3-bit conversion-clock select, and a control register holds a START bit plus a read-only, active-low "conversion finished" flag. A prescaler derives a conversion-clock enable from the system clock. Each conversion takes one sample period, twelve bit trials from the MSB down, and one completion period, which makes fourteen conversion clocks.

On each trial the sequencer drives a trial code to an external DAC and reads back one comparator bit. When the conversion completes, it latches the result, clears the finished flag, and sets a sticky interrupt request flag. That flag drives the interrupt output only while the interrupt is enabled. Software may poll the finished flag instead of using the interrupt.

A conversion is launched only by a full low-high-low pulse on START. While START is high, the sequencer is held in reset.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x80, address 1 reads 0x02 (finished flag high, START low), address 2 reads 0x00, and `irq` is 0.
- R2: Address 0 layout: bit 7 is a test bit (reset 1), bit 6 is power-down (1 = off, reset 0), bits 5..3 always read 0, and bits 2..0 are the clock select. Writing 0xFF reads back 0xC7.
- R3: Clock select to conversion-clock divisor: 100 = 1, 000 = 2, 101 = 4, 001 = 8, 110 = 16, 010 = 32. A conversion completes exactly 14 x divisor system-clock cycles after the edge that writes START back to 0.
- R4: The trial code is 0 during the sample period, then starts at 0x800. On each trial edge the tested bit is kept when `cmp_in` is 1 (trial code <= input) and cleared otherwise, and the next lower bit is set. The final code becomes `conv_result`.
- R5: Writing START = 1 alone starts nothing. While START stays high the finished flag reads 1, no conversion completes, and `irq` stays 0.
- R6: Address 1 layout: bit 0 is START and bit 1 is the read-only active-low finished flag. Writing START = 1 sets the flag to 1; hardware clears it to 0 when a conversion completes.
- R7: With a reserved clock select (011 or 111), a START pulse launches nothing. The flag stays 1, and `conv_result` and `dac_code` do not change.
- R8: With power-down set, a START pulse launches nothing and the flag stays 1.
- R9: A new START pulse during a conversion aborts it and leaves `conv_result` unchanged. The restarted conversion completes 14 x divisor cycles after its own launch.
- R10: Address 2 layout: bit 0 is the interrupt request flag and bit 1 is the interrupt enable. The flag is set at completion and stays set until software writes 0 to bit 0; writing 1 to bit 0 leaves it unchanged. `irq` = flag AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator: 1 when trial code <= analog input |
| dac_code | output | 12 | Current trial code to the DAC |
| conv_result | output | 12 | Last completed conversion result |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest situation to reach is an abort. A second START pulse must land mid-conversion and be followed by a clean restart, and the bench must show that no result or interrupt leaks from the abandoned run. The stimulus launches at the slowest divisor and waits a hundred cycles into the bit trials. It then raises START, reads the held state, and changes the modelled analog input before lowering START. A completion carrying the old input value, or one arriving at the wrong cycle, therefore mismatches the scoreboard. The blocked launches under power-down and under the reserved codes are reached the same way, by pulsing START after the configuration write.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    localparam int BUS_W = 8;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_INT  = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_TRIAL,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] log2_div;
    } div_cfg_t;

    // Non-monotonic select encoding; 011 and 111 are reserved.
    function automatic div_cfg_t decode_sel(input logic [2:0] sel);
        div_cfg_t d;
        d.valid = 1'b1;
        unique case (sel)
            3'b100:  d.log2_div = 3'd0;
            3'b000:  d.log2_div = 3'd1;
            3'b101:  d.log2_div = 3'd2;
            3'b001:  d.log2_div = 3'd3;
            3'b110:  d.log2_div = 3'd4;
            3'b010:  d.log2_div = 3'd5;
            default: begin
                d.valid    = 1'b0;
                d.log2_div = 3'd0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
    parameter int MAX_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] log2_div,
    output logic       tick
);
    localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((32'd1 << log2_div) - 32'd1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sar_stepper.sv
module sar_stepper
    import sar_conv_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             launch,
    input  logic             tick,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             conv_done
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] nxt_trial;

    always_comb begin
        nxt_trial = trial;
        if (!cmp_in) nxt_trial[idx] = 1'b0;
        if (idx != '0) nxt_trial[idx - 1'b1] = 1'b1;
    end

    assign conv_done = tick && (phase == PH_FINISH) && !hold && !launch;
    assign dac_code  = trial;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            trial  <= '0;
            result <= '0;
        end else if (launch) begin
            phase <= PH_SAMPLE;
            trial <= '0;
        end else if (hold) begin
            phase <= PH_IDLE;
        end else if (tick) begin
            unique case (phase)
                PH_SAMPLE: begin
                    phase <= PH_TRIAL;
                    idx   <= TOP_IDX;
                    trial <= {1'b1, {(RES_W-1){1'b0}}};
                end
                PH_TRIAL: begin
                    trial <= nxt_trial;
                    if (idx == '0) phase <= PH_FINISH;
                    else           idx   <= idx - 1'b1;
                end
                PH_FINISH: begin
                    result <= trial;
                    phase  <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: the result changes only on a normal completion
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(result));

    // R8: without a conversion-clock enable the sequence does not move
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (!tick && !launch && !hold) |=> ($stable(phase) && $stable(trial)));

endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             conv_done,
    output logic             pwr_dn,
    output logic [2:0]       clk_sel,
    output logic             start_q,
    output logic             launch_req,
    output logic             irq_flag,
    output logic             irq_en
);
    logic test_bit;
    logic done_n;
    logic cfg_wr, ctrl_wr, int_wr;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata[5:3];

    assign cfg_wr  = bus_we && (bus_addr == ADDR_CFG);
    assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
    assign int_wr  = bus_we && (bus_addr == ADDR_INT);

    // falling edge of START written by software
    assign launch_req = ctrl_wr && start_q && !bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            test_bit <= 1'b1;
            pwr_dn   <= 1'b0;
            clk_sel  <= 3'b000;
            start_q  <= 1'b0;
            done_n   <= 1'b1;
            irq_flag <= 1'b0;
            irq_en   <= 1'b0;
        end else begin
            if (cfg_wr) begin
                test_bit <= bus_wdata[7];
                pwr_dn   <= bus_wdata[6];
                clk_sel  <= bus_wdata[2:0];
            end
            if (ctrl_wr) start_q <= bus_wdata[0];

            if (ctrl_wr && bus_wdata[0]) done_n <= 1'b1;
            else if (conv_done)          done_n <= 1'b0;

            if (conv_done)                      irq_flag <= 1'b1;
            else if (int_wr && !bus_wdata[0])   irq_flag <= 1'b0;
            if (int_wr) irq_en <= bus_wdata[1];
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CFG:  bus_rdata = {test_bit, pwr_dn, 3'b000, clk_sel};
            ADDR_CTRL: bus_rdata = {6'b0, done_n, start_q};
            ADDR_INT:  bus_rdata = {6'b0, irq_en, irq_flag};
            default:   bus_rdata = '0;
        endcase
    end

    // R5: while START is held high the converter reads busy
    a_r5_hold_busy: assert property (@(posedge clk) disable iff (rst)
        start_q |-> done_n);

    // R6: completion clears the finished flag
    a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !(ctrl_wr && bus_wdata[0])) |=> !done_n);

    // R10: the request flag survives anything but a write of 0
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !(int_wr && !bus_wdata[0])) |=> irq_flag);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int MAX_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] conv_result,
    output logic             irq
);
    logic       pwr_dn, start_q, launch_req, irq_flag, irq_en;
    logic [2:0] clk_sel;
    logic       run_ok, launch, tick, conv_done;
    div_cfg_t   div_cfg;

    assign div_cfg = decode_sel(clk_sel);
    assign run_ok  = !pwr_dn && div_cfg.valid;
    assign launch  = launch_req && run_ok;
    assign irq     = irq_flag && irq_en;

    sar_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .conv_done  (conv_done),
        .pwr_dn     (pwr_dn),
        .clk_sel    (clk_sel),
        .start_q    (start_q),
        .launch_req (launch_req),
        .irq_flag   (irq_flag),
        .irq_en     (irq_en)
    );

    sar_prescale #(.MAX_LOG2(MAX_LOG2)) u_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (launch || start_q),
        .run      (run_ok),
        .log2_div (div_cfg.log2_div),
        .tick     (tick)
    );

    sar_stepper #(.RES_W(RES_W)) u_step (
        .clk       (clk),
        .rst       (rst),
        .hold      (start_q),
        .launch    (launch),
        .tick      (tick),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .result    (conv_result),
        .conv_done (conv_done)
    );

    // R7/R8: a START pulse refused by the configuration leaves the trial code alone
    a_r7_blocked_launch: assert property (@(posedge clk) disable iff (rst)
        (launch_req && !run_ok) |=> $stable(dac_code));

endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

    typedef struct {
        int     val;
        longint cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic [11:0] conv_result;
    logic        irq;
    logic [11:0] vin = 12'd0;

    int     checks = 0;
    int     errs = 0;
    longint cyc = 0;
    exp_t   sb[$];
    logic   irq_prev = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // comparator model
    assign cmp_in = (dac_code <= vin);

    sar_conv_ctrl i_sar_conv_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cmp_in      (cmp_in),
        .dac_code    (dac_code),
        .conv_result (conv_result),
        .irq         (irq)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int divisor(input logic [2:0] code);
        case (code)
            3'b100: return 1;
            3'b000: return 2;
            3'b101: return 4;
            3'b001: return 8;
            3'b110: return 16;
            default: return 32;
        endcase
    endfunction

    // monitor: each rising irq must match the oldest expected completion
    always @(negedge clk) begin
        if (!rst && irq && !irq_prev) begin
            if (sb.size() == 0) begin
                checks++; errs++;
                $display("FAIL R10 unexpected irq actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R4 result", conv_result, e.val);
                chk("R3 completion cycle", cyc, e.cyc);
            end
        end
        irq_prev = irq;
    end

    task automatic wait_empty();
        for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
        chk("R3 completion seen", sb.size(), 0);
        sb.delete();
    endtask

    task automatic run_conv(input logic [2:0] code, input logic [11:0] v, input bit dac_chk);
        logic [7:0] r;
        exp_t e;
        int d;
        d = divisor(code);
        wr(2'd0, {5'b0, code});
        vin = v;
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        e.val = int'(v); e.cyc = cyc + 14 * d;
        sb.push_back(e);
        if (dac_chk) begin
            chk("R4 dac zero in sample", dac_code, 0);
            repeat (d) @(negedge clk);
            chk("R4 dac first trial", dac_code, 12'h800);
        end
        wait_empty();
        rd(2'd1, r);
        chk("R6 finished flag low", r, 8'h00);
        chk("R10 irq asserted", irq, 1);
        repeat (5) @(negedge clk);
        chk("R10 irq sticky", irq, 1);
        wr(2'd2, 8'h03);
        chk("R10 write 1 keeps flag", irq, 1);
        wr(2'd2, 8'h02);
        chk("R10 write 0 clears flag", irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [11:0] keep;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        rd(2'd0, r); chk("R1 cfg reset", r, 8'h80);
        rd(2'd1, r); chk("R1 ctrl reset", r, 8'h02);
        rd(2'd2, r); chk("R1 int reset", r, 8'h00);
        chk("R1 irq reset", irq, 0);

        wr(2'd0, 8'hFF);
        rd(2'd0, r); chk("R2 unimplemented bits", r, 8'hC7);
        wr(2'd0, 8'h04);
        rd(2'd0, r); chk("R2 cfg readback", r, 8'h04);

        wr(2'd2, 8'h02);

        // R5: START held high
        wr(2'd1, 8'h01);
        rd(2'd1, r); chk("R5 start held busy", r, 8'h03);
        repeat (50) @(negedge clk);
        rd(2'd1, r); chk("R5 still busy", r, 8'h03);
        chk("R5 no irq", irq, 0);
        wr(2'd1, 8'h00);
        sb.push_back('{val: 0, cyc: cyc + 14});
        wait_empty();
        wr(2'd2, 8'h02);

        run_conv(3'b100, 12'hA5C, 1'b0);
        run_conv(3'b000, 12'h123, 1'b1);
        run_conv(3'b101, 12'h000, 1'b0);
        run_conv(3'b001, 12'h800, 1'b0);
        run_conv(3'b110, 12'h7FF, 1'b0);
        run_conv(3'b010, 12'hFFF, 1'b0);
        run_conv(3'b000, 12'h3C3, 1'b0);

        // R7: reserved selects
        keep = conv_result;
        for (int k = 0; k < 2; k++) begin
            wr(2'd0, (k == 0) ? 8'h03 : 8'h07);
            vin = 12'h456;
            wr(2'd1, 8'h01);
            wr(2'd1, 8'h00);
            repeat (60) @(negedge clk);
            rd(2'd1, r); chk("R7 reserved no launch", r, 8'h02);
            chk("R7 result unchanged", conv_result, keep);
            chk("R7 irq quiet", irq, 0);
        end

        // R8: powered down
        wr(2'd0, 8'h44);
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        repeat (60) @(negedge clk);
        rd(2'd1, r); chk("R8 power-down no launch", r, 8'h02);
        chk("R8 result unchanged", conv_result, keep);

        // R9: abort and restart
        wr(2'd0, 8'h02);
        vin = 12'h111;
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        repeat (100) @(negedge clk);
        wr(2'd1, 8'h01);
        rd(2'd1, r); chk("R9 abort holds busy", r, 8'h03);
        chk("R9 result kept", conv_result, keep);
        vin = 12'hABC;
        wr(2'd1, 8'h00);
        sb.push_back('{val: 12'hABC, cyc: cyc + 14 * 32});
        wait_empty();
        wr(2'd2, 8'h02);

        // R10: interrupt disabled, polled completion
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h04);
        vin = 12'h5A5;
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        repeat (20) @(negedge clk);
        chk("R10 irq gated by enable", irq, 0);
        rd(2'd2, r); chk("R10 flag set while disabled", r, 8'h01);
        rd(2'd1, r); chk("R6 polled finish", r, 8'h00);
        chk("R4 polled result", conv_result, 12'h5A5);
        wr(2'd2, 8'h00);
        rd(2'd2, r); chk("R10 flag cleared", r, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule